// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches up to 54 already-synchronized GPIO levels and records per-pin events in status words that software reads and clears over a simple 32-bit register port. Pins are grouped into 32-pin banks: pin p lives in bank p/32 at bit p%32. Each pin has four independent trigger enables (rising edge, falling edge, high level, low level) held in separate per-bank words. A status bit is set by any enabled trigger, in any mix.

Edges are found by comparing the current sample of a pin with the sample taken on the previous clock. Level triggers set the status bit on every cycle the level is present, so a cleared bit comes straight back while the level persists. Software clears status bits by writing ones. Each bank drives its own interrupt line, high while any status bit of that bank is set.

The register port takes a write in the cycle `bus_wr` is high and returns read data one cycle after `bus_rd`. Word offsets per bank b: status 0x40+4b, rising enable 0x4C+4b, falling enable 0x58+4b, high-level enable 0x64+4b, low-level enable 0x70+4b. All other offsets read as zero and ignore writes.

Top module: `gpev_top`

## Requirements
- R1: After reset every enable word and status word reads zero, `bus_rdata` is zero and every `irq_bank` line is low; the previous-sample history is cleared to low.
- R2: With the rising enable set, a pin that was low on the previous clock and is high now sets its status bit at that clock edge.
- R3: With the falling enable set, a pin that was high on the previous clock and is low now sets its status bit at that clock edge.
- R4: With both edge enables set, a pin sets its status bit on each rising and each falling transition.
- R5: With the high-level enable set, the status bit is set on every clock the pin is high, so it is set again right after a clear while the pin stays high.
- R6: With the low-level enable set, the status bit is set on every clock the pin is low.
- R7: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a trigger and a clearing write hit the same status bit on the same clock, the bit stays set.
- R9: Writing an enable bit to 0 does not clear a status bit already latched.
- R10: `irq_bank[b]` is high exactly while some status bit of bank b is set; pin p drives bank p/32 only.
- R11: Bits for pin numbers at or above the pin count read as zero in all words and can never be set; offsets outside the map read zero.
- R12: Enable words written at their offsets read back the written value (masked per R11) on the cycle after the read strobe.
- R13: A pin with all four enables clear never sets its status bit, whatever it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_bank | output | NUM_BANKS | One interrupt line per 32-pin bank |

## Verification
A pin change applied between clocks becomes a status bit and an interrupt level after exactly one rising clock edge, so the bench changes pins just after a falling edge and samples `irq_bank` at the next falling edge, having crossed a single rising edge. Writes take effect at the rising edge inside the strobe cycle, and read data is registered at the rising edge where `bus_rd` is high, so each read task raises the strobe for one cycle and samples `bus_rdata` at the following falling edge. The set-over-clear case drives the clearing write and the pin change in the same cycle so that both land on one rising edge.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    // Word offsets of bank 0; bank b adds 4*b
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RISE   = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_FALL   = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_HIGH   = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_LOW    = 8'h70;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_RISE,
        SEL_FALL,
        SEL_HIGH,
        SEL_LOW
    } word_sel_e;

endpackage

// File: rtl/gpev_decode.sv
module gpev_decode
    import gpev_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BANK_IW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    output word_sel_e          sel,
    output logic [BANK_IW-1:0] bank
);

    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_BANKS);

    logic [ADDR_W-1:0] d_status, d_rise, d_fall, d_high, d_low;

    assign d_status = addr - OFS_STATUS;
    assign d_rise   = addr - OFS_RISE;
    assign d_fall   = addr - OFS_FALL;
    assign d_high   = addr - OFS_HIGH;
    assign d_low    = addr - OFS_LOW;

    function automatic logic in_window(input logic [ADDR_W-1:0] d);
        return (d < SPAN) && (d[1:0] == 2'b00);
    endfunction

    always_comb begin
        sel  = SEL_NONE;
        bank = '0;
        if (in_window(d_status)) begin
            sel  = SEL_STATUS;
            bank = BANK_IW'(d_status >> 2);
        end else if (in_window(d_rise)) begin
            sel  = SEL_RISE;
            bank = BANK_IW'(d_rise >> 2);
        end else if (in_window(d_fall)) begin
            sel  = SEL_FALL;
            bank = BANK_IW'(d_fall >> 2);
        end else if (in_window(d_high)) begin
            sel  = SEL_HIGH;
            bank = BANK_IW'(d_high >> 2);
        end else if (in_window(d_low)) begin
            sel  = SEL_LOW;
            bank = BANK_IW'(d_low >> 2);
        end
    end

endmodule

// File: rtl/gpev_detect.sv
module gpev_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    input  logic [W-1:0] en_high,
    input  logic [W-1:0] en_low,
    output logic [W-1:0] cause
);

    logic [W-1:0] went_up, went_down;

    assign went_up   = lvl & ~prev;
    assign went_down = ~lvl & prev;

    assign cause = (en_rise & went_up)
                 | (en_fall & went_down)
                 | (en_high & lvl)
                 | (en_low  & ~lvl);

endmodule

// File: rtl/gpev_bank.sv
module gpev_bank #(
    parameter int W          = 32,
    parameter int VALID_BITS = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         wr_status,
    input  logic         wr_rise,
    input  logic         wr_fall,
    input  logic         wr_high,
    input  logic         wr_low,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_q,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q,
    output logic [W-1:0] high_q,
    output logic [W-1:0] low_q,
    output logic         irq
);

    localparam logic [W-1:0] VMASK = (VALID_BITS >= W) ? {W{1'b1}}
                                   : ((W'(1) << VALID_BITS) - W'(1));

    logic [W-1:0] prev_q;
    logic [W-1:0] cause;
    logic [W-1:0] clr_mask;
    logic [W-1:0] wmasked;

    assign wmasked  = wdata & VMASK;
    assign clr_mask = wr_status ? wdata : '0;

    gpev_detect #(.W(W)) u_detect (
        .lvl     (lvl),
        .prev    (prev_q),
        .en_rise (rise_q),
        .en_fall (fall_q),
        .en_high (high_q),
        .en_low  (low_q),
        .cause   (cause)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
            high_q   <= '0;
            low_q    <= '0;
        end else begin
            prev_q   <= lvl & VMASK;
            status_q <= ((status_q & ~clr_mask) | cause) & VMASK;
            if (wr_rise) rise_q <= wmasked;
            if (wr_fall) fall_q <= wmasked;
            if (wr_high) high_q <= wmasked;
            if (wr_low)  low_q  <= wmasked;
        end
    end

    assign irq = |status_q;

endmodule

// File: rtl/gpev_top.sv
module gpev_top
    import gpev_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_lvl,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_BANKS-1:0] irq_bank
);

    localparam int TOTAL   = NUM_BANKS * WORD_W;
    localparam int BANK_IW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [TOTAL-1:0]   lvl_pad;
    word_sel_e          dec_sel;
    logic [BANK_IW-1:0] dec_bank;

    logic [WORD_W-1:0] status_arr [NUM_BANKS];
    logic [WORD_W-1:0] rise_arr   [NUM_BANKS];
    logic [WORD_W-1:0] fall_arr   [NUM_BANKS];
    logic [WORD_W-1:0] high_arr   [NUM_BANKS];
    logic [WORD_W-1:0] low_arr    [NUM_BANKS];

    // Flattened views, also observed by the bound checker
    logic [TOTAL-1:0] status_flat, rise_flat, fall_flat, high_flat, low_flat;

    logic [WORD_W-1:0] rd_mux;

    assign lvl_pad = TOTAL'(pin_lvl);

    gpev_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .addr (bus_addr),
        .sel  (dec_sel),
        .bank (dec_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int VBITS = NUM_PINS - b * WORD_W;
        logic hit;

        assign hit = bus_wr && (dec_bank == BANK_IW'(b));

        gpev_bank #(
            .W          (WORD_W),
            .VALID_BITS (VBITS)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (lvl_pad[b*WORD_W +: WORD_W]),
            .wr_status (hit && (dec_sel == SEL_STATUS)),
            .wr_rise   (hit && (dec_sel == SEL_RISE)),
            .wr_fall   (hit && (dec_sel == SEL_FALL)),
            .wr_high   (hit && (dec_sel == SEL_HIGH)),
            .wr_low    (hit && (dec_sel == SEL_LOW)),
            .wdata     (bus_wdata),
            .status_q  (status_arr[b]),
            .rise_q    (rise_arr[b]),
            .fall_q    (fall_arr[b]),
            .high_q    (high_arr[b]),
            .low_q     (low_arr[b]),
            .irq       (irq_bank[b])
        );

        assign status_flat[b*WORD_W +: WORD_W] = status_arr[b];
        assign rise_flat[b*WORD_W +: WORD_W]   = rise_arr[b];
        assign fall_flat[b*WORD_W +: WORD_W]   = fall_arr[b];
        assign high_flat[b*WORD_W +: WORD_W]   = high_arr[b];
        assign low_flat[b*WORD_W +: WORD_W]    = low_arr[b];
    end

    always_comb begin
        unique case (dec_sel)
            SEL_STATUS: rd_mux = status_arr[dec_bank];
            SEL_RISE:   rd_mux = rise_arr[dec_bank];
            SEL_FALL:   rd_mux = fall_arr[dec_bank];
            SEL_HIGH:   rd_mux = high_arr[dec_bank];
            SEL_LOW:    rd_mux = low_arr[dec_bank];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/gpev_chk.sv
module gpev_chk
    import gpev_pkg::*;
#(
    parameter int NUM_PINS   = 54,
    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int TOTAL     = NUM_BANKS * WORD_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PINS-1:0]  pin_lvl,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic [NUM_BANKS-1:0] irq_bank,
    input logic [TOTAL-1:0]     status_flat,
    input logic [TOTAL-1:0]     rise_flat,
    input logic [TOTAL-1:0]     fall_flat,
    input logic [TOTAL-1:0]     high_flat,
    input logic [TOTAL-1:0]     low_flat
);

    logic [TOTAL-1:0] valid, lvl_c, prev_c, cause_c, clr_c;

    assign valid = TOTAL'({NUM_PINS{1'b1}});
    assign lvl_c = TOTAL'(pin_lvl);

    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= lvl_c;
    end

    assign cause_c = ((lvl_c & ~prev_c & rise_flat) | (~lvl_c & prev_c & fall_flat)
                   | (lvl_c & high_flat) | (~lvl_c & low_flat)) & valid;

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            clr_c[b*WORD_W +: WORD_W] =
                (bus_wr && (bus_addr == ADDR_W'(OFS_STATUS + ADDR_W'(4 * b)))) ? bus_wdata : '0;
        end
    end

    AST_CAUSE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_flat & $past(cause_c)) == $past(cause_c))); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_c & cause_c) & ~status_flat) == '0)); // R8

    AST_FALL_ONLY_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status_flat) & ~status_flat & ~$past(clr_c)) == '0)); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_flat | rise_flat | fall_flat | high_flat | low_flat) & ~valid) == '0)); // R11

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
        AST_IRQ_ROSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_bank[b]) |-> $past(|cause_c[b*WORD_W +: WORD_W])); // R10

        AST_IRQ_FELL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_bank[b]) |-> $past(bus_wr)); // R10
    end

endmodule

bind gpev_top gpev_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl     (pin_lvl),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq_bank    (irq_bank),
    .status_flat (status_flat),
    .rise_flat   (rise_flat),
    .fall_flat   (fall_flat),
    .high_flat   (high_flat),
    .low_flat    (low_flat)
);

// File: tb/gpev_top_test.sv
module gpev_top_test;

    localparam int NP = 54;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [1:0]    irq_bank;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    gpev_top #(.NUM_PINS(NP)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_bank  (irq_bank)
    );

    always #10 clk = ~clk;

    localparam logic [7:0] A_ST0 = 8'h40, A_ST1 = 8'h44;
    localparam logic [7:0] A_RI0 = 8'h4C, A_RI1 = 8'h50;
    localparam logic [7:0] A_FA0 = 8'h58, A_FA1 = 8'h5C;
    localparam logic [7:0] A_HI0 = 8'h64, A_HI1 = 8'h68;
    localparam logic [7:0] A_LO0 = 8'h70, A_LO1 = 8'h74;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pin_lvl[p] = v;
    endtask

    task automatic clear_all();
        wr(A_RI0, 0); wr(A_RI1, 0); wr(A_FA0, 0); wr(A_FA1, 0);
        wr(A_HI0, 0); wr(A_HI1, 0); wr(A_LO0, 0); wr(A_LO1, 0);
        wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        logic [7:0] addrs [10] = '{A_ST0, A_ST1, A_RI0, A_RI1, A_FA0, A_FA1,
                                   A_HI0, A_HI1, A_LO0, A_LO1};
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 0);
        check("R1 irq after reset", {30'd0, irq_bank}, 0);
        for (int i = 0; i < 10; i++) begin
            rd(addrs[i], v);
            check("R1 word after reset", v, 0);
        end
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_FA0, 32'hA5A5_5A5A);
        rd(A_FA0, v); check("R12 falling enable bank0 readback", v, 32'hA5A5_5A5A);
        wr(A_LO1, 32'hFFFF_FFFF);
        rd(A_LO1, v); check("R11 upper bank bits masked", v, 32'h003F_FFFF);
        rd(8'h48, v); check("R11 unmapped status slot", v, 0);
        rd(8'h00, v); check("R11 unmapped offset", v, 0);
        wr(A_FA0, 0); wr(A_LO1, 0);
        wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
        rd(A_ST1, v); check("R11 status bank1 cleared", v, 0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(A_RI0, 32'h8);
        set_pin(3, 1'b1);
        check("R2 irq before edge", {31'd0, irq_bank[0]}, 0);
        @(negedge clk);
        check("R2 irq one edge after rise", {31'd0, irq_bank[0]}, 1);
        rd(A_ST0, v); check("R2 status bit3", v, 32'h8);
        wr(A_ST0, 32'h8);
        check("R10 irq drops after clear", {30'd0, irq_bank}, 0);
        set_pin(3, 1'b0);
        @(negedge clk);
        rd(A_ST0, v); check("R2 falling edge ignored", v, 0);
        // R8: clear and new rise on the same edge
        set_pin(3, 1'b1);
        set_pin(3, 1'b0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_ST0; bus_wdata = 32'h8; pin_lvl[3] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(A_ST0, v); check("R8 set wins over clear", v, 32'h8);
        wr(A_RI0, 0);
        rd(A_ST0, v); check("R9 status kept after disable", v, 32'h8);
        clear_all();
        set_pin(3, 1'b0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        set_pin(40, 1'b1);
        wr(A_FA1, 32'h100);
        set_pin(40, 1'b0);
        @(negedge clk);
        check("R3/R10 irq bank1 only", {30'd0, irq_bank}, 32'h2);
        rd(A_ST1, v); check("R3 status pin40", v, 32'h100);
        clear_all();
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(A_RI0, 32'h20); wr(A_FA0, 32'h20);
        set_pin(5, 1'b1);
        @(negedge clk);
        rd(A_ST0, v); check("R4 rise seen", v, 32'h20);
        wr(A_ST0, 32'h20);
        set_pin(5, 1'b0);
        @(negedge clk);
        rd(A_ST0, v); check("R4 fall seen", v, 32'h20);
        clear_all();
    endtask

    task automatic t_high();
        logic [31:0] v;
        wr(A_HI0, 32'h400);
        set_pin(10, 1'b1);
        @(negedge clk);
        check("R5 irq on high level", {31'd0, irq_bank[0]}, 1);
        wr(A_ST0, 32'h400);
        rd(A_ST0, v); check("R5 re-set while high", v, 32'h400);
        set_pin(10, 1'b0);
        wr(A_ST0, 32'h400);
        rd(A_ST0, v); check("R5 stays clear when low", v, 0);
        clear_all();
    endtask

    task automatic t_low();
        logic [31:0] v;
        wr(A_LO0, 32'h0010_0000);
        @(negedge clk);
        rd(A_ST0, v); check("R6 low level sets", v, 32'h0010_0000);
        // R7: clear one bit, keep another
        wr(A_HI0, 32'h1);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        wr(A_HI0, 0); wr(A_LO0, 0);
        wr(A_ST0, 32'h0010_0000);
        rd(A_ST0, v); check("R7 zero bits untouched", v, 32'h1);
        clear_all();
    endtask

    task automatic t_noenable();
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pin_lvl = ~pin_lvl;
        end
        pin_lvl = '0;
        @(negedge clk);
        rd(A_ST0, v); check("R13 no enable bank0", v, 0);
        rd(A_ST1, v); check("R13 no enable bank1", v, 0);
        check("R13 irq idle", {30'd0, irq_bank}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_rise();
        t_fall();
        t_both();
        t_high();
        t_low();
        t_noenable();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule